// File: doc/BRIEF.md
# Frame-Transfer Sensor Field Timing Generator

This block derives every field-rate control signal for a frame-transfer image sensor from one master clock. A prescaler produces the pixel clock. Pixel and line counters split each field into active lines and blanking. From those counters the block drives the readout qualifiers for the digital video path: a line enable, a frame enable and a field identifier. It also drives an anti-blooming gate that is active during horizontal and vertical blanking.

Each field, once vertical blanking begins, a sequencer waits a configured number of clocks. It then issues an exact-count burst of parallel-transfer pulses, which shifts the charge image one line per pulse from the light-sensitive area into the masked storage area. The stored field is read out during the active lines of the following field while the image area integrates again. The burst stays inside vertical blanking, so it can never collide with readout. All counts, dividers and blanking lengths are parameters. The defaults give a 242-pulse burst with an 8-clock pulse period.

Top module: `ftg_top`

## Requirements
- R1: A synchronous, active-high reset drives every output low and restarts the field. After reset is released, the first clock edge moves the timing to position t=1, where t counts clock edges since release.
- R2: `pix_clk_o` is high for the first PIX_DIV/2 (rounded down) clocks of every PIX_DIV-clock pixel period and low for the rest.
- R3: `line_en_o` is high exactly while the pixel index is below H_ACTIVE and the line index is below V_ACTIVE. A line has H_ACTIVE+H_BLANK pixels.
- R4: `frame_en_o` is high during the V_ACTIVE active lines and low for all V_BLANK blanking lines. When it falls, the line enable is already low and the anti-blooming gate is high.
- R5: `ab_gate_o` is high during horizontal blanking and during vertical blanking, and never while `line_en_o` is high.
- R6: `field_id_o` starts at 0 and toggles exactly once per field, on the first clock of vertical blanking, which is the same clock on which `frame_en_o` falls.
- R7: The first transfer pulse rises XFER_DELAY clocks after vertical blanking begins. Each pulse period is XFER_PERIOD clocks, and the pulse is high for its first XFER_PERIOD/2 (rounded down) clocks.
- R8: Exactly XFER_PULSES transfer pulses occur in each vertical blanking interval.
- R9: `xfer_o` is never high while `frame_en_o` is high, so the transfer never overlaps storage readout.
- R10: The field period is PIX_DIV*(H_ACTIVE+H_BLANK)*(V_ACTIVE+V_BLANK) clocks, and every output pattern repeats identically from field to field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk_o | output | 1 | Pixel clock for the video path |
| line_en_o | output | 1 | High during active pixels of active lines |
| frame_en_o | output | 1 | High during active lines of the field |
| field_id_o | output | 1 | Field parity, toggles at each vertical blanking start |
| ab_gate_o | output | 1 | Anti-blooming gate, high in any blanking |
| xfer_o | output | 1 | Parallel-transfer pulse train into storage |

## Verification
If the raster counters are wrong, the line and frame enables shift within the first line, and the field identifier moves off its field boundary by the end of the first field. If the transfer sequencer holds a wrong delay, phase or pulse counter, the first vertical blanking shows it. Either the first pulse edge lands on the wrong clock or the count of pulses before the next active line differs. Every output is compared on every clock against an arithmetic model of clock position. Two small configurations are used, one with a zero start delay and an odd pulse period, so a fault appears at the first differing cycle.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t line;
        cnt_t pix;
        cnt_t sub;
    } raster_pos_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_mode_e;

    function automatic cnt_t wrap_inc(input cnt_t v, input cnt_t last);
        return (v == last) ? '0 : v + cnt_t'(1);
    endfunction

endpackage

// File: rtl/ftg_raster.sv
module ftg_raster
    import ftg_pkg::*;
#(
    parameter int PIX_DIV  = 2,
    parameter int H_TOTAL  = 910,
    parameter int V_TOTAL  = 262,
    parameter int V_ACTIVE = 244
) (
    input  logic        clk,
    input  logic        rst,
    output raster_pos_t pos_nx,
    output logic        vb_start_nx
);
    localparam cnt_t SUB_LAST  = cnt_t'(PIX_DIV - 1);
    localparam cnt_t PIX_LAST  = cnt_t'(H_TOTAL - 1);
    localparam cnt_t LINE_LAST = cnt_t'(V_TOTAL - 1);
    localparam cnt_t VB_LINE   = cnt_t'(V_ACTIVE);

    raster_pos_t pos_q;

    always_comb begin
        pos_nx = pos_q;
        pos_nx.sub = wrap_inc(pos_q.sub, SUB_LAST);
        if (pos_q.sub == SUB_LAST) begin
            pos_nx.pix = wrap_inc(pos_q.pix, PIX_LAST);
            if (pos_q.pix == PIX_LAST)
                pos_nx.line = wrap_inc(pos_q.line, LINE_LAST);
        end
        if (rst)
            pos_nx = '0;
    end

    assign vb_start_nx = !rst && (pos_nx.line == VB_LINE) &&
                         (pos_nx.pix == '0) && (pos_nx.sub == '0);

    always_ff @(posedge clk) begin
        pos_q <= pos_nx;
    end

endmodule

// File: rtl/ftg_xfer_seq.sv
module ftg_xfer_seq
    import ftg_pkg::*;
#(
    parameter int XFER_PULSES = 242,
    parameter int XFER_PERIOD = 8,
    parameter int XFER_DELAY  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic vb_start_nx,
    output logic xfer_o
);
    localparam cnt_t PH_LAST  = cnt_t'(XFER_PERIOD - 1);
    localparam cnt_t PH_HIGH  = cnt_t'(XFER_PERIOD / 2);
    localparam cnt_t K_LAST   = cnt_t'(XFER_PULSES - 1);
    localparam cnt_t DLY      = cnt_t'(XFER_DELAY);
    localparam bit   NO_WAIT  = (XFER_DELAY == 0);

    seq_mode_e mode_q, mode_n;
    cnt_t      cnt_q, cnt_n;
    cnt_t      k_q, k_n;

    always_comb begin
        mode_n = mode_q;
        cnt_n  = cnt_q;
        k_n    = k_q;
        if (vb_start_nx) begin
            mode_n = NO_WAIT ? SEQ_RUN : SEQ_WAIT;
            cnt_n  = '0;
            k_n    = '0;
        end else begin
            case (mode_q)
                SEQ_WAIT: begin
                    if (cnt_q + cnt_t'(1) == DLY) begin
                        mode_n = SEQ_RUN;
                        cnt_n  = '0;
                    end else begin
                        cnt_n = cnt_q + cnt_t'(1);
                    end
                end
                SEQ_RUN: begin
                    if (cnt_q == PH_LAST) begin
                        cnt_n = '0;
                        if (k_q == K_LAST) mode_n = SEQ_IDLE;
                        else               k_n    = k_q + cnt_t'(1);
                    end else begin
                        cnt_n = cnt_q + cnt_t'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SEQ_IDLE;
            cnt_q  <= '0;
            k_q    <= '0;
            xfer_o <= 1'b0;
        end else begin
            mode_q <= mode_n;
            cnt_q  <= cnt_n;
            k_q    <= k_n;
            xfer_o <= (mode_n == SEQ_RUN) && (cnt_n < PH_HIGH);
        end
    end

    // R8: the pulse index never runs past the last pulse of the burst
    a_r8_index_bound: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SEQ_RUN) |-> (k_q <= K_LAST));

endmodule

// File: rtl/ftg_top.sv
module ftg_top
    import ftg_pkg::*;
#(
    parameter int PIX_DIV     = 2,
    parameter int H_ACTIVE    = 780,
    parameter int H_BLANK     = 130,
    parameter int V_ACTIVE    = 244,
    parameter int V_BLANK     = 18,
    parameter int XFER_PULSES = 242,
    parameter int XFER_PERIOD = 8,
    parameter int XFER_DELAY  = 64
) (
    input  logic clk,
    input  logic rst,
    output logic pix_clk_o,
    output logic line_en_o,
    output logic frame_en_o,
    output logic field_id_o,
    output logic ab_gate_o,
    output logic xfer_o
);
    localparam int   H_TOTAL = H_ACTIVE + H_BLANK;
    localparam int   V_TOTAL = V_ACTIVE + V_BLANK;
    localparam cnt_t PCLK_HI = cnt_t'(PIX_DIV / 2);
    localparam cnt_t H_ACT_C = cnt_t'(H_ACTIVE);
    localparam cnt_t V_ACT_C = cnt_t'(V_ACTIVE);

    raster_pos_t nx;
    logic        vb_start_nx;
    logic        act_line_n, act_pix_n;

    ftg_raster #(
        .PIX_DIV (PIX_DIV),
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL),
        .V_ACTIVE(V_ACTIVE)
    ) u_raster (
        .clk        (clk),
        .rst        (rst),
        .pos_nx     (nx),
        .vb_start_nx(vb_start_nx)
    );

    ftg_xfer_seq #(
        .XFER_PULSES(XFER_PULSES),
        .XFER_PERIOD(XFER_PERIOD),
        .XFER_DELAY (XFER_DELAY)
    ) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .vb_start_nx(vb_start_nx),
        .xfer_o     (xfer_o)
    );

    assign act_line_n = nx.line < V_ACT_C;
    assign act_pix_n  = nx.pix < H_ACT_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_clk_o  <= 1'b0;
            line_en_o  <= 1'b0;
            frame_en_o <= 1'b0;
            field_id_o <= 1'b0;
            ab_gate_o  <= 1'b0;
        end else begin
            pix_clk_o  <= nx.sub < PCLK_HI;
            line_en_o  <= act_line_n && act_pix_n;
            frame_en_o <= act_line_n;
            ab_gate_o  <= !(act_line_n && act_pix_n);
            if (vb_start_nx)
                field_id_o <= !field_id_o;
        end
    end

    // checker state: transfer pulses seen since the current blanking began
    cnt_t chk_pulses;
    logic chk_xfer_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_pulses <= '0;
            chk_xfer_d <= 1'b0;
        end else begin
            chk_xfer_d <= xfer_o;
            if (frame_en_o)
                chk_pulses <= '0;
            else if (xfer_o && !chk_xfer_d)
                chk_pulses <= chk_pulses + cnt_t'(1);
        end
    end

    // R9: transfer only while readout is halted
    a_r9_xfer_in_vblank: assert property (@(posedge clk) disable iff (rst)
        xfer_o |-> !frame_en_o);

    // R6: field parity moves only on the clock where the frame enable falls
    a_r6_fid_at_vblank: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_id_o) |-> $fell(frame_en_o));

    // R4: entering vertical blanking leaves line enable low and the gate high
    a_r4_vblank_entry: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_en_o) |-> (!line_en_o && ab_gate_o));

    // R5: the gate and the line enable never overlap
    a_r5_gate_excl: assert property (@(posedge clk) disable iff (rst)
        line_en_o |-> !ab_gate_o);

    // R8: no more pulses than configured within one blanking interval
    a_r8_pulse_count: assert property (@(posedge clk) disable iff (rst)
        chk_pulses <= cnt_t'(XFER_PULSES));

endmodule

// File: tb/sim_ftg_top.sv
module sim_ftg_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit hung  = 1'b0;

    // configuration A
    localparam int A_PD = 2, A_HA = 6, A_HB = 3, A_VA = 5, A_VB = 4;
    localparam int A_N = 10, A_PER = 4, A_DLY = 7;
    // configuration B: zero delay, odd pulse period, odd pixel divider
    localparam int B_PD = 3, B_HA = 4, B_HB = 2, B_VA = 3, B_VB = 3;
    localparam int B_N = 5, B_PER = 3, B_DLY = 0;

    logic [5:0] a_out, b_out;

    ftg_top #(.PIX_DIV(A_PD), .H_ACTIVE(A_HA), .H_BLANK(A_HB), .V_ACTIVE(A_VA),
              .V_BLANK(A_VB), .XFER_PULSES(A_N), .XFER_PERIOD(A_PER),
              .XFER_DELAY(A_DLY)) u0 (
        .clk(clk), .rst(rst),
        .pix_clk_o(a_out[0]), .line_en_o(a_out[1]), .frame_en_o(a_out[2]),
        .field_id_o(a_out[3]), .ab_gate_o(a_out[4]), .xfer_o(a_out[5]));

    ftg_top #(.PIX_DIV(B_PD), .H_ACTIVE(B_HA), .H_BLANK(B_HB), .V_ACTIVE(B_VA),
              .V_BLANK(B_VB), .XFER_PULSES(B_N), .XFER_PERIOD(B_PER),
              .XFER_DELAY(B_DLY)) u1 (
        .clk(clk), .rst(rst),
        .pix_clk_o(b_out[0]), .line_en_o(b_out[1]), .frame_en_o(b_out[2]),
        .field_id_o(b_out[3]), .ab_gate_o(b_out[4]), .xfer_o(b_out[5]));

    // expected {xfer, ab, fid, frame_en, line_en, pix_clk} at position t
    function automatic logic [5:0] model(input int t, input int pd, input int ha,
                                         input int hb, input int va, input int vb,
                                         input int n, input int per, input int dly);
        int htot, ln, fr, sub, pix, line, vbs, u, r, nf;
        logic [5:0] e;
        htot = ha + hb;
        ln   = pd * htot;
        fr   = ln * (va + vb);
        sub  = t % pd;
        pix  = (t / pd) % htot;
        line = (t / ln) % (va + vb);
        vbs  = va * ln;
        e[0] = sub < pd / 2;
        e[1] = (pix < ha) && (line < va);
        e[2] = line < va;
        nf   = (t >= vbs) ? ((t - vbs) / fr + 1) : 0;
        e[3] = nf[0];
        e[4] = !e[1];
        e[5] = 1'b0;
        if (t >= vbs) begin
            u = t - vbs;
            r = u % fr;
            if (r >= dly && r < dly + n * per && ((r - dly) % per) < per / 2)
                e[5] = 1'b1;
        end
        return e;
    endfunction

    function automatic string req_of(input int b);
        case (b)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic cmp(input string tag, input string inst, input int t,
                       input logic [5:0] got, input logic [5:0] exp);
        for (int b = 0; b < 6; b++) begin
            total++;
            if (got[b] !== exp[b]) begin
                bad++;
                $display("FAIL %s %s %s t=%0d bit%0d got=%b exp=%b",
                         req_of(b), tag, inst, t, b, got[b], exp[b]);
            end
        end
    endtask

    task automatic chk1(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    // R10: the run spans several fields, so field-to-field repetition is covered
    task automatic run_span(input int cycles, input string tag);
        int a_cnt, b_cnt;
        logic a_px, b_px, a_fe, b_fe;
        a_cnt = 0; b_cnt = 0;
        a_px = 1'b0; b_px = 1'b0; a_fe = 1'b0; b_fe = 1'b0;
        for (int t = 1; t <= cycles; t++) begin
            @(negedge clk);
            cmp(tag, "u0", t, a_out, model(t, A_PD, A_HA, A_HB, A_VA, A_VB, A_N, A_PER, A_DLY));
            cmp(tag, "u1", t, b_out, model(t, B_PD, B_HA, B_HB, B_VA, B_VB, B_N, B_PER, B_DLY));
            // R8: pulses counted over each blanking interval
            if (a_out[5] && !a_px) a_cnt++;
            if (b_out[5] && !b_px) b_cnt++;
            if (a_out[2] && !a_fe && t > 1) begin
                chk1("R8", "u0 pulses per blanking", a_cnt, A_N);
                a_cnt = 0;
            end
            if (b_out[2] && !b_fe && t > 1) begin
                chk1("R8", "u1 pulses per blanking", b_cnt, B_N);
                b_cnt = 0;
            end
            // R9: no transfer while frame enable is high
            if ((a_out[5] && a_out[2]) || (b_out[5] && b_out[2]))
                chk1("R9", "xfer during readout", 1, 0);
            a_px = a_out[5]; b_px = b_out[5];
            a_fe = a_out[2]; b_fe = b_out[2];
        end
    endtask

    initial begin
        #2_000_000;
        hung = 1'b1;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low while reset is held
        chk1("R1", "u0 outputs in reset", int'(a_out), 0);
        chk1("R1", "u1 outputs in reset", int'(b_out), 0);
        rst = 1'b0;
        run_span(700, "first");
        // R1: reset in mid-field clears and restarts the timing
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk1("R1", "u0 outputs in mid-run reset", int'(a_out), 0);
        chk1("R1", "u1 outputs in mid-run reset", int'(b_out), 0);
        rst = 1'b0;
        run_span(450, "second");
        if (!hung) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule